// File: doc/BRIEF.md
# T1/E1 Loopback and Receive-Conditioning Path

This block sits between the receive and transmit bit streams of a T1/E1 framer. It handles the per-bit work that follows framing. Each receive bit arrives with a 2-bit class tag that marks it as framing, signaling or payload. On the way out to the system, the block conditions the receive stream in three steps. First it can replace payload bytes of chosen channels with a digital milliwatt tone, using either the u-law or the A-law pattern. Next it can invert one bit class. Last it can drive the output to all ones while frame alignment is lost.

The block also provides two test loopbacks. In payload loopback, the received payload and signaling bits are sent back out on the line. The transmit frame position follows the receiver. For overhead bit positions, the block raises a strobe that asks the transmit section to regenerate those bits. In framer loopback, the transmit stream is fed into the receive path in place of line data, and the transmit channel gate outputs are held low. The line then carries all ones in T1 mode, or the normal transmit stream in E1 mode.

The loopback selection is latched only on the first bit of a frame, so a mode change never produces a partial frame. All outputs are registered, so each one appears one clock after the bit it belongs to.

Top module: `t1e1_loop_cond`

## Requirements
- R1: While `rst` is high, every output is 0 on the following clock. After reset, neither loopback is active, and the milliwatt byte index is set so that the first frame start selects byte 0.
- R2: With no loopback active and every conditioning control at 0, the following hold one clock later: `rx_ser_o` equals `rx_bit`, `tx_line_o` equals `tx_ser`, `tx_sync_o` equals `tx_sync_in`, the two channel gate outputs equal their inputs, and `tx_regen_o` is 0.
- R3: Class tags are encoded as 0 = none, 1 = framing, 2 = signaling, 3 = payload. `ctl_inv_sel` works as follows: 0 inverts nothing, 1 inverts framing bits, 2 inverts signaling bits, and 3 inverts payload bits. Bits of any other class are untouched.
- R4: When `ctl_force_ones` is 1 and `rx_lof` is 1, `rx_ser_o` is 1 on the next clock. This stage acts after inversion and milliwatt insertion. When `ctl_force_ones` is 0, `rx_lof` has no effect on the output.
- R5: Insertion applies to payload bits whose channel bit in `mw_chan_mask` is set. Such a bit is replaced by a bit of milliwatt byte k, sent MSB first. The u-law bytes are 1E,0B,0B,1E,9E,8B,8B,9E and the A-law bytes are 34,21,21,34,B4,A1,A1,B4. `ctl_alaw` = 1 selects the A-law set. k advances by one (mod 8) at each frame start. In T1 mode, frame bit 0 has no channel, and bit p ≥ 1 belongs to channel (p-1)/8, at bit (p-1) mod 8. In E1 mode, bit p belongs to channel p/8, at bit p mod 8.
- R6: In payload loopback, every signaling or payload bit is sent as `tx_line_o` = the received `rx_bit`. Every other bit is sent from `tx_ser` with `tx_regen_o` = 1. This gives 192 looped bits per T1 frame and 248 per E1 frame when time slots 0 and 16 are the only E1 overhead and signaling slots.
- R7: In payload loopback, `tx_sync_o` is taken from `rx_sync` instead of `tx_sync_in`.
- R8: In framer loopback, `rx_bit` is ignored and the receive path takes its data from `tx_ser`. `tx_chclk_o` and `tx_chblk_o` are 0.
- R9: In framer loopback, `tx_line_o` is 1 in T1 mode (`e1_mode` = 0) and equals `tx_ser` in E1 mode.
- R10: When both loopback controls are set, framer loopback applies and payload loopback is inactive.
- R11: The loopback controls are sampled only on a bit with `rx_sync` = 1. That bit and the rest of its frame use the sampled mode, and a change made mid-frame has no effect before the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 0 = T1 frame (193 bits), 1 = E1 frame (256 bits) |
| ctl_alaw | input | 1 | Milliwatt pattern select, 1 = A-law |
| ctl_force_ones | input | 1 | Force receive output to ones during loss of frame |
| ctl_inv_sel | input | 2 | Class-selective inversion code |
| ctl_plb | input | 1 | Request payload loopback |
| ctl_flb | input | 1 | Request framer loopback |
| mw_chan_mask | input | 32 | Per-channel milliwatt insertion enable |
| rx_bit | input | 1 | Received data bit |
| rx_cls | input | 2 | Class tag of `rx_bit` |
| rx_sync | input | 1 | First bit of a receive frame |
| rx_lof | input | 1 | Loss of frame alignment |
| tx_ser | input | 1 | Transmit data bit from the transmit section |
| tx_sync_in | input | 1 | Transmit frame sync from the transmit section |
| tx_chclk_in | input | 1 | Transmit channel clock gate in |
| tx_chblk_in | input | 1 | Transmit channel block gate in |
| rx_ser_o | output | 1 | Conditioned receive data |
| tx_line_o | output | 1 | Data toward the line |
| tx_sync_o | output | 1 | Transmit frame sync source |
| tx_regen_o | output | 1 | Request to regenerate an overhead bit |
| tx_chclk_o | output | 1 | Transmit channel clock gate out |
| tx_chblk_o | output | 1 | Transmit channel block gate out |

## Verification
The bench drives random data in both T1 and E1 frame layouts, with framing, signaling and payload tags laid out per frame. This separates class-selective inversion from whole-stream inversion, and T1 channel numbering from E1 channel numbering. Milliwatt runs span nine frames under sparse channel masks, in both laws. This exposes wrong byte order, wrong bit order inside a byte, or insertion into the wrong channel or into framing positions. The loopback runs use a transmit sync placed away from the receive sync, and they count the looped bits in each frame. A swapped sync source or a wrong overhead rule therefore shows up at once. Mid-frame control changes show whether the mode is latched at the frame boundary or applied early.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_FRAME = 2'd1,
    CLS_SIG   = 2'd2,
    CLS_PAY   = 2'd3
  } bit_cls_e;

  // Digital milliwatt byte k of the selected law
  function automatic logic [7:0] mw_byte(input logic alaw, input logic [2:0] k);
    logic [7:0] u, a;
    case (k)
      3'd0, 3'd3: begin u = 8'h1E; a = 8'h34; end
      3'd1, 3'd2: begin u = 8'h0B; a = 8'h21; end
      3'd4, 3'd7: begin u = 8'h9E; a = 8'hB4; end
      default:    begin u = 8'h8B; a = 8'hA1; end
    endcase
    return alaw ? a : u;
  endfunction

endpackage

// File: rtl/lc_mode_sync.sv
module lc_mode_sync (
  input  logic clk,
  input  logic rst,
  input  logic rx_sync,
  input  logic req_plb,
  input  logic req_flb,
  output logic plb_act,
  output logic flb_act
);

  logic plb_q, flb_q;

  always_comb begin
    flb_act = rx_sync ? req_flb : flb_q;
    plb_act = (rx_sync ? req_plb : plb_q) & ~flb_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plb_q <= 1'b0;
      flb_q <= 1'b0;
    end else if (rx_sync) begin
      plb_q <= req_plb;
      flb_q <= req_flb;
    end
  end

  // R11: mode state only moves on a frame-start bit
  a_r11_mode_holds_mid_frame: assert property (@(posedge clk) disable iff (rst)
    !rx_sync |=> (plb_q == $past(plb_q)) && (flb_q == $past(flb_q)));

endmodule

// File: rtl/lc_frame_pos.sv
module lc_frame_pos #(
  parameter int FRAME_T1 = 193,
  parameter int FRAME_E1 = 256,
  parameter int POS_W    = $clog2(FRAME_E1),
  parameter int CH_W     = POS_W - 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            e1_mode,
  input  logic            rx_sync,
  output logic [CH_W-1:0] chan,
  output logic [2:0]      bit_idx,
  output logic            chan_ok,
  output logic [2:0]      byte_idx
);

  logic [POS_W-1:0] pos_q, pos_cur, pos_m1, pos_last;
  logic [2:0]       byte_q;

  always_comb begin
    pos_last = e1_mode ? POS_W'(FRAME_E1 - 1) : POS_W'(FRAME_T1 - 1);
    if (rx_sync)
      pos_cur = '0;
    else if (pos_q == pos_last)
      pos_cur = '0;
    else
      pos_cur = pos_q + 1'b1;
    pos_m1   = pos_cur - 1'b1;
    byte_idx = rx_sync ? byte_q + 3'd1 : byte_q;
    if (e1_mode) begin
      chan    = pos_cur[POS_W-1:3];
      bit_idx = pos_cur[2:0];
      chan_ok = 1'b1;
    end else begin
      chan    = pos_m1[POS_W-1:3];
      bit_idx = pos_m1[2:0];
      chan_ok = (pos_cur != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      byte_q <= 3'd7;
    end else begin
      pos_q  <= pos_cur;
      byte_q <= byte_idx;
    end
  end

  // R5: pattern byte index steps once per frame start
  a_r5_byte_steps: assert property (@(posedge clk) disable iff (rst)
    rx_sync |=> byte_q == 3'($past(byte_q) + 3'd1));

endmodule

// File: rtl/lc_rx_cond.sv
module lc_rx_cond #(
  parameter int CHANS = 32,
  parameter int CH_W  = $clog2(CHANS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_bit,
  input  logic [1:0]       cls,
  input  logic [CH_W-1:0]  chan,
  input  logic [2:0]       bit_idx,
  input  logic             chan_ok,
  input  logic [2:0]       byte_idx,
  input  logic [CHANS-1:0] mask,
  input  logic             alaw,
  input  logic [1:0]       inv_sel,
  input  logic             force_ones,
  input  logic             lof,
  output logic             rx_ser_o
);
  import lc_pkg::*;

  logic [7:0] mw_b;
  logic       ins, b_mw, b_inv, b_out;

  always_comb begin
    mw_b  = mw_byte(alaw, byte_idx);
    ins   = (bit_cls_e'(cls) == CLS_PAY) && chan_ok && mask[chan];
    b_mw  = ins ? mw_b[3'd7 - bit_idx] : src_bit;
    b_inv = ((inv_sel != 2'd0) && (inv_sel == cls)) ? ~b_mw : b_mw;
    b_out = (force_ones && lof) ? 1'b1 : b_inv;
  end

  always_ff @(posedge clk) begin
    if (rst) rx_ser_o <= 1'b0;
    else     rx_ser_o <= b_out;
  end

  // R4: forced ones under loss of frame
  a_r4_force_ones: assert property (@(posedge clk) disable iff (rst)
    (force_ones && lof) |=> rx_ser_o);

  // R3: with no inversion code, non-payload bits pass unchanged
  a_r3_no_inv_passes: assert property (@(posedge clk) disable iff (rst)
    (inv_sel == 2'd0 && !(force_ones && lof) && cls != 2'd3) |=> rx_ser_o == $past(src_bit));

endmodule

// File: rtl/lc_tx_path.sv
module lc_tx_path (
  input  logic       clk,
  input  logic       rst,
  input  logic       e1_mode,
  input  logic       plb_act,
  input  logic       flb_act,
  input  logic       rx_bit,
  input  logic [1:0] cls,
  input  logic       rx_sync,
  input  logic       tx_ser,
  input  logic       tx_sync_in,
  input  logic       chclk_in,
  input  logic       chblk_in,
  output logic       tx_line_o,
  output logic       tx_sync_o,
  output logic       regen_o,
  output logic       chclk_o,
  output logic       chblk_o
);
  import lc_pkg::*;

  logic looped, line_d;

  always_comb begin
    looped = (bit_cls_e'(cls) == CLS_SIG) || (bit_cls_e'(cls) == CLS_PAY);
    if (flb_act)
      line_d = e1_mode ? tx_ser : 1'b1;
    else if (plb_act)
      line_d = looped ? rx_bit : tx_ser;
    else
      line_d = tx_ser;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line_o <= 1'b0;
      tx_sync_o <= 1'b0;
      regen_o   <= 1'b0;
      chclk_o   <= 1'b0;
      chblk_o   <= 1'b0;
    end else begin
      tx_line_o <= line_d;
      tx_sync_o <= plb_act ? rx_sync : tx_sync_in;
      regen_o   <= plb_act & ~looped;
      chclk_o   <= chclk_in & ~flb_act;
      chblk_o   <= chblk_in & ~flb_act;
    end
  end

  // R1: reset clears every transmit-side output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !tx_line_o && !tx_sync_o && !regen_o && !chclk_o && !chblk_o);

  // R6: looped classes carry the received bit with no regeneration request
  a_r6_payload_looped: assert property (@(posedge clk) disable iff (rst)
    (plb_act && looped) |=> (tx_line_o == $past(rx_bit)) && !regen_o);

  // R7: transmit sync follows the receiver in payload loopback
  a_r7_sync_from_rx: assert property (@(posedge clk) disable iff (rst)
    plb_act |=> tx_sync_o == $past(rx_sync));

  // R8: channel gates held low in framer loopback
  a_r8_gates_low: assert property (@(posedge clk) disable iff (rst)
    flb_act |=> !chclk_o && !chblk_o);

  // R9: T1 framer loopback sends all ones
  a_r9_t1_all_ones: assert property (@(posedge clk) disable iff (rst)
    (flb_act && !e1_mode) |=> tx_line_o);

endmodule

// File: rtl/t1e1_loop_cond.sv
module t1e1_loop_cond #(
  parameter int FRAME_T1 = 193,
  parameter int FRAME_E1 = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        e1_mode,
  input  logic        ctl_alaw,
  input  logic        ctl_force_ones,
  input  logic [1:0]  ctl_inv_sel,
  input  logic        ctl_plb,
  input  logic        ctl_flb,
  input  logic [31:0] mw_chan_mask,
  input  logic        rx_bit,
  input  logic [1:0]  rx_cls,
  input  logic        rx_sync,
  input  logic        rx_lof,
  input  logic        tx_ser,
  input  logic        tx_sync_in,
  input  logic        tx_chclk_in,
  input  logic        tx_chblk_in,
  output logic        rx_ser_o,
  output logic        tx_line_o,
  output logic        tx_sync_o,
  output logic        tx_regen_o,
  output logic        tx_chclk_o,
  output logic        tx_chblk_o
);

  localparam int POS_W = $clog2(FRAME_E1);
  localparam int CH_W  = POS_W - 3;
  localparam int CHANS = FRAME_E1 / 8;

  logic            plb_act, flb_act, src_bit, chan_ok;
  logic [CH_W-1:0] chan;
  logic [2:0]      bit_idx, byte_idx;

  lc_mode_sync u_mode (
    .clk(clk), .rst(rst), .rx_sync(rx_sync),
    .req_plb(ctl_plb), .req_flb(ctl_flb),
    .plb_act(plb_act), .flb_act(flb_act)
  );

  lc_frame_pos #(.FRAME_T1(FRAME_T1), .FRAME_E1(FRAME_E1), .POS_W(POS_W), .CH_W(CH_W)) u_pos (
    .clk(clk), .rst(rst), .e1_mode(e1_mode), .rx_sync(rx_sync),
    .chan(chan), .bit_idx(bit_idx), .chan_ok(chan_ok), .byte_idx(byte_idx)
  );

  assign src_bit = flb_act ? tx_ser : rx_bit;

  lc_rx_cond #(.CHANS(CHANS), .CH_W(CH_W)) u_rx (
    .clk(clk), .rst(rst), .src_bit(src_bit), .cls(rx_cls),
    .chan(chan), .bit_idx(bit_idx), .chan_ok(chan_ok), .byte_idx(byte_idx),
    .mask(mw_chan_mask[CHANS-1:0]), .alaw(ctl_alaw), .inv_sel(ctl_inv_sel),
    .force_ones(ctl_force_ones), .lof(rx_lof), .rx_ser_o(rx_ser_o)
  );

  lc_tx_path u_tx (
    .clk(clk), .rst(rst), .e1_mode(e1_mode),
    .plb_act(plb_act), .flb_act(flb_act),
    .rx_bit(rx_bit), .cls(rx_cls), .rx_sync(rx_sync),
    .tx_ser(tx_ser), .tx_sync_in(tx_sync_in),
    .chclk_in(tx_chclk_in), .chblk_in(tx_chblk_in),
    .tx_line_o(tx_line_o), .tx_sync_o(tx_sync_o), .regen_o(tx_regen_o),
    .chclk_o(tx_chclk_o), .chblk_o(tx_chblk_o)
  );

  // R8: in framer loopback the receive output follows the transmit stream
  a_r8_rx_from_tx: assert property (@(posedge clk) disable iff (rst)
    (flb_act && !(ctl_force_ones && rx_lof) && ctl_inv_sel == 2'd0 && rx_cls != 2'd3)
      |=> rx_ser_o == $past(tx_ser));

  // R10: framer loopback wins when both are requested at a frame start
  a_r10_flb_wins: assert property (@(posedge clk) disable iff (rst)
    (ctl_flb && ctl_plb && rx_sync) |=> !tx_regen_o && (tx_sync_o == $past(tx_sync_in)));

endmodule

// File: tb/tb_t1e1_loop_cond.sv
`timescale 1ns/1ps
module tb_t1e1_loop_cond;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e1_mode = 0, ctl_alaw = 0, ctl_force_ones = 0, ctl_plb = 0, ctl_flb = 0;
  logic [1:0]  ctl_inv_sel = 0;
  logic [31:0] mw_chan_mask = 0;
  logic rx_bit = 0, rx_sync = 0, rx_lof = 0, tx_ser = 0, tx_sync_in = 0;
  logic tx_chclk_in = 0, tx_chblk_in = 0;
  logic [1:0] rx_cls = 0;
  logic rx_ser_o, tx_line_o, tx_sync_o, tx_regen_o, tx_chclk_o, tx_chblk_o;

  t1e1_loop_cond dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, frm = 0, loop_cnt = 0;
  bit lof_rand = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_plb = 0, m_flb = 0;
  int m_pos = 0, m_idx = 7;
  bit e_rx = 0, e_line = 0, e_sync = 0, e_regen = 0, e_chclk = 0, e_chblk = 0;
  byte unsigned ulaw [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
  byte unsigned alaw [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};

  function automatic int flen();
    return e1_mode ? 256 : 193;
  endfunction

  task automatic model();
    bit fl, pl, b, lp;
    int ch, bi;
    bit has;
    byte unsigned pat;
    if (rst) begin
      m_plb = 0; m_flb = 0; m_pos = 0; m_idx = 7;
      {e_rx, e_line, e_sync, e_regen, e_chclk, e_chblk} = '0;
      return;
    end
    if (rx_sync) begin m_flb = ctl_flb; m_plb = ctl_plb; end
    fl = m_flb; pl = m_plb && !m_flb;
    if (rx_sync) m_pos = 0; else m_pos = (m_pos == flen() - 1) ? 0 : m_pos + 1;
    if (rx_sync) m_idx = (m_idx + 1) % 8;
    if (e1_mode) begin ch = m_pos / 8; bi = m_pos % 8; has = 1; end
    else begin ch = (m_pos - 1) / 8; bi = (m_pos - 1) % 8; has = (m_pos != 0); end
    b = fl ? tx_ser : rx_bit;
    if (rx_cls == 3 && has && mw_chan_mask[ch]) begin
      pat = ctl_alaw ? alaw[m_idx] : ulaw[m_idx];
      b = pat[7 - bi];
    end
    if (ctl_inv_sel != 0 && ctl_inv_sel == rx_cls) b = !b;
    if (ctl_force_ones && rx_lof) b = 1;
    e_rx = b;
    lp = (rx_cls == 2 || rx_cls == 3);
    if (fl) e_line = e1_mode ? tx_ser : 1'b1;
    else if (pl) e_line = lp ? rx_bit : tx_ser;
    else e_line = tx_ser;
    e_sync = pl ? rx_sync : tx_sync_in;
    e_regen = pl && !lp;
    e_chclk = tx_chclk_in && !fl;
    e_chblk = tx_chblk_in && !fl;
  endtask

  task automatic chk(input string what, input logic got, input bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic tick();
    model();
    @(negedge clk);
    chk("rx_ser_o", rx_ser_o, e_rx);
    chk("tx_line_o", tx_line_o, e_line);
    chk("tx_sync_o", tx_sync_o, e_sync);
    chk("tx_regen_o", tx_regen_o, e_regen);
    chk("tx_chclk_o", tx_chclk_o, e_chclk);
    chk("tx_chblk_o", tx_chblk_o, e_chblk);
    if (tx_regen_o === 1'b0) loop_cnt++;
  endtask

  function automatic logic [1:0] cls_at(int p);
    if (e1_mode) begin
      if (p < 8) return 2'd1;
      if (p >= 128 && p < 136) return 2'd2;
      return 2'd3;
    end
    if (p == 0) return 2'd1;
    if ((frm % 2 == 1) && ((p - 1) % 8 == 7)) return 2'd2;
    return 2'd3;
  endfunction

  task automatic run_range(input int first, input int last);
    for (int p = first; p <= last; p++) begin
      if (p == 0) frm++;
      rx_sync     = (p == 0);
      rx_cls      = cls_at(p);
      rx_bit      = 1'($urandom);
      tx_ser      = 1'($urandom);
      tx_sync_in  = (p == 7);
      tx_chclk_in = 1'($urandom);
      tx_chblk_in = 1'($urandom);
      rx_lof      = lof_rand ? ($urandom % 4 == 0) : 1'b0;
      tick();
    end
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n; i++) run_range(0, flen() - 1);
  endtask

  task automatic count_frame(input int expect_n);
    run_range(0, 0);
    loop_cnt = 0;
    run_range(1, flen() - 1);
    run_range(0, 0);
    checks++;
    if (loop_cnt != expect_n) begin
      fails++;
      $display("FAIL R6 looped bits per frame got %0d expected %0d", loop_cnt, expect_n);
    end
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    run_range(0, 3);
    rst = 0;
    // R2: plain pass-through, both frame layouts
    cur_req = "R2";
    run_frames(2);
    e1_mode = 1; run_frames(1); e1_mode = 0;
    // R3: each inversion code in both layouts
    cur_req = "R3";
    for (int c = 1; c < 4; c++) begin
      ctl_inv_sel = 2'(c);
      run_frames(2);
      e1_mode = 1; run_frames(1); e1_mode = 0;
    end
    ctl_inv_sel = 0;
    // R4: force ones under loss of frame, then loss ignored when disabled
    cur_req = "R4";
    lof_rand = 1; ctl_force_ones = 1; ctl_inv_sel = 2'd3;
    run_frames(2);
    ctl_force_ones = 0; run_frames(1);
    lof_rand = 0; ctl_inv_sel = 0;
    // R5: milliwatt insertion, u-law T1 then A-law E1
    cur_req = "R5";
    mw_chan_mask = 32'h0080_0021; ctl_alaw = 0;
    run_frames(9);
    e1_mode = 1; ctl_alaw = 1; mw_chan_mask = 32'h8001_0003;
    run_frames(9);
    ctl_inv_sel = 2'd3; run_frames(1); ctl_inv_sel = 0;
    mw_chan_mask = 0; ctl_alaw = 0; e1_mode = 0;
    // R7 / R6: payload loopback
    cur_req = "R7";
    ctl_plb = 1; run_frames(2);
    cur_req = "R6";
    count_frame(192);
    run_range(1, flen() - 1);
    e1_mode = 1; run_frames(1);
    count_frame(248);
    run_range(1, flen() - 1);
    ctl_plb = 0; e1_mode = 0; run_frames(1);
    // R8 / R9: framer loopback in T1 and E1
    cur_req = "R9";
    ctl_flb = 1; run_frames(2);
    cur_req = "R8";
    e1_mode = 1; run_frames(2);
    e1_mode = 0;
    // R10: both requested
    cur_req = "R10";
    ctl_plb = 1; run_frames(2);
    ctl_plb = 0; ctl_flb = 0; run_frames(1);
    // R11: mid-frame changes wait for the next frame start
    cur_req = "R11";
    run_range(0, 99);
    ctl_plb = 1;
    run_range(100, flen() - 1);
    run_range(0, 60);
    ctl_flb = 1;
    run_range(61, flen() - 1);
    run_range(0, 30);
    ctl_flb = 0; ctl_plb = 0;
    run_range(31, flen() - 1);
    run_frames(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule